// File: doc/BRIEF.md
# Atomic Event Ordering Monitor

This block sits beside a retirement stage and follows the instructions of one multi-line atomic event as they retire, one per cycle. It tracks which cache lines take part in the event, moves through idle, setup and manifestation phases, and flags with a fault pulse and cause code any event whose instructions break the required phase order or that names more lines than it can hold. It pulses a completion output when the single locked store that ends the event retires.

Each retiring instruction arrives as a valid strobe with an operation code, a cache-line tag and a lock bit. Operation codes are 1 event start, 2 locked load, 3 plain load, 4 query, 5 store. Codes 0, 6 and 7 are ignored. The phase output reads 00 idle, 01 setup and 10 manifestation. All outputs are registered, so the effect of an instruction shows on the cycle after the edge that accepts it. Coherence, interference detection and the memory updates themselves are handled elsewhere.

Top module: `atomic_order_monitor`

## Requirements
- R1: After reset the phase is 00, faultPulse and donePulse are 0, faultCause is 00, warnSticky is 0 and lineCount is 0.
- R2: In idle, an event start (op 1) moves the phase to setup, empties the line table and clears warnSticky. Every other operation in idle leaves phase, lineCount and the pulses unchanged.
- R3: In setup, a locked load (op 2) to a line not in the table adds it, so lineCount rises by one. A locked load to a line already present leaves lineCount unchanged.
- R4: A locked load to a new line while the table holds MAX_LINES lines raises a fault with cause 10. A locked load that hits a line already present in a full table does not fault.
- R5: A query (op 4) in setup moves the phase to manifestation. A query in manifestation raises a fault with cause 01.
- R6: In manifestation, a locked load, or a plain load (op 3) to a participating line, raises a fault with cause 01.
- R7: In manifestation, a plain load to a non-participating line raises no fault and sets warnSticky. warnSticky then holds until the next event start from idle. A plain load during setup does not set it.
- R8: A store (op 5) with the lock bit clear to a participating line moves setup to manifestation. A store with the lock bit clear to a non-participating line has no effect.
- R9: A store with the lock bit set to a participating line, in setup or manifestation, pulses donePulse. It returns the phase to idle and empties the table.
- R10: A store with the lock bit set to a non-participating line raises a fault with cause 11.
- R11: An event start while an event is active raises a fault with cause 01.
- R12: faultPulse and donePulse last one cycle. faultCause is non-zero exactly while faultPulse is high. After a fault or completion, the phase is idle and lineCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A retiring instruction is presented this cycle |
| instOp | input | 3 | Operation code (1 start, 2 locked load, 3 plain load, 4 query, 5 store) |
| instTag | input | TAG_W | Cache-line tag of the access |
| instLock | input | 1 | Lock bit of a store |
| phase | output | 2 | Current phase: 00 idle, 01 setup, 10 manifestation |
| faultPulse | output | 1 | One-cycle operation fault |
| faultCause | output | 2 | 01 order, 10 line limit, 11 locked store to non-participating line |
| donePulse | output | 1 | One-cycle event completion |
| warnSticky | output | 1 | Non-participating load seen during manifestation |
| lineCount | output | CNT_W | Number of participating lines held |

## Verification
The table lookup and the capacity check judge the same locked load in the same cycle, and the two can conflict when the table is full. The bench fills the table to MAX_LINES lines. It then issues a locked load that hits an existing line, which must not fault and must leave lineCount at MAX_LINES. It follows with a locked load to a fresh line, which must fault with cause 10 and leave the phase idle and lineCount at 0 on the same cycle.

// File: rtl/atomic_order_monitor_pkg.sv
package atomic_order_monitor_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_SETUP = 2'b01,
    PH_MANIF = 2'b10
  } phase_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ORDER  = 2'b01,
    CAUSE_LIMIT  = 2'b10,
    CAUSE_NOLINE = 2'b11
  } cause_e;

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_LLOAD = 3'd2;
  localparam logic [2:0] OP_PLOAD = 3'd3;
  localparam logic [2:0] OP_QUERY = 3'd4;
  localparam logic [2:0] OP_STORE = 3'd5;

  typedef struct packed {
    logic alloc;
    logic clear;
  } tbl_strobe_t;

endpackage

// File: rtl/amon_line_table.sv
module amon_line_table
  import atomic_order_monitor_pkg::*;
#(
  parameter int MAX_LINES = 8,
  parameter int TAG_W     = 26,
  parameter int CNT_W     = $clog2(MAX_LINES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TAG_W-1:0]   lookTag,
  input  tbl_strobe_t        strb,
  output logic               lineHit,
  output logic               tableFull,
  output logic [CNT_W-1:0]   lineCount
);

  localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;

  logic [MAX_LINES-1:0] entryVld;
  logic [TAG_W-1:0]     entryTag [MAX_LINES];
  logic [MAX_LINES-1:0] entryMatch;
  logic [IDX_W-1:0]     freeIdx;
  logic [CNT_W-1:0]     cnt;

  for (genvar g = 0; g < MAX_LINES; g++) begin : g_cmp
    assign entryMatch[g] = entryVld[g] && (entryTag[g] == lookTag);
  end

  assign lineHit = |entryMatch;

  always_comb begin
    freeIdx = '0;
    for (int i = MAX_LINES - 1; i >= 0; i--) begin
      if (!entryVld[i]) freeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < MAX_LINES; i++) begin
      cnt = cnt + CNT_W'(entryVld[i]);
    end
  end

  assign lineCount = cnt;
  assign tableFull = (cnt == CNT_W'(MAX_LINES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryVld <= '0;
    end else if (strb.clear) begin
      entryVld <= '0;
    end else if (strb.alloc && !lineHit && !tableFull) begin
      entryVld[freeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.alloc && !lineHit && !tableFull) begin
      entryTag[freeIdx] <= lookTag;
    end
  end

endmodule

// File: rtl/amon_ctrl.sv
module amon_ctrl
  import atomic_order_monitor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [2:0]  instOp,
  input  logic        instLock,
  input  logic        lineHit,
  input  logic        tableFull,
  output tbl_strobe_t strb,
  output phase_e      phase,
  output logic        faultPulse,
  output cause_e      faultCause,
  output logic        donePulse,
  output logic        warnSticky
);

  phase_e phNext;
  cause_e causeNext;
  logic   doneNext;
  logic   warnNext;

  always_comb begin
    phNext     = phase;
    causeNext  = CAUSE_NONE;
    doneNext   = 1'b0;
    warnNext   = warnSticky;
    strb       = '0;
    if (instValid) begin
      if (phase == PH_IDLE) begin
        if (instOp == OP_START) begin
          phNext     = PH_SETUP;
          strb.clear = 1'b1;
          warnNext   = 1'b0;
        end
      end else begin
        case (instOp)
          OP_START: causeNext = CAUSE_ORDER;
          OP_LLOAD: begin
            if (phase != PH_SETUP)  causeNext  = CAUSE_ORDER;
            else if (!lineHit) begin
              if (tableFull)        causeNext  = CAUSE_LIMIT;
              else                  strb.alloc = 1'b1;
            end
          end
          OP_PLOAD: begin
            if (phase == PH_MANIF) begin
              if (lineHit) causeNext = CAUSE_ORDER;
              else         warnNext  = 1'b1;
            end
          end
          OP_QUERY: begin
            if (phase == PH_SETUP) phNext    = PH_MANIF;
            else                   causeNext = CAUSE_ORDER;
          end
          OP_STORE: begin
            if (instLock) begin
              if (lineHit) doneNext  = 1'b1;
              else         causeNext = CAUSE_NOLINE;
            end else if (lineHit) begin
              phNext = PH_MANIF;
            end
          end
          default: ;
        endcase
        if (causeNext != CAUSE_NONE || doneNext) begin
          phNext     = PH_IDLE;
          strb.clear = 1'b1;
          strb.alloc = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      faultPulse <= 1'b0;
      faultCause <= CAUSE_NONE;
      donePulse  <= 1'b0;
      warnSticky <= 1'b0;
    end else begin
      phase      <= phNext;
      faultPulse <= (causeNext != CAUSE_NONE);
      faultCause <= causeNext;
      donePulse  <= doneNext;
      warnSticky <= warnNext;
    end
  end

endmodule

// File: rtl/atomic_order_monitor.sv
module atomic_order_monitor
  import atomic_order_monitor_pkg::*;
#(
  parameter int MAX_LINES = 8,
  parameter int TAG_W     = 26,
  parameter int CNT_W     = $clog2(MAX_LINES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [2:0]       instOp,
  input  logic [TAG_W-1:0] instTag,
  input  logic             instLock,
  output logic [1:0]       phase,
  output logic             faultPulse,
  output logic [1:0]       faultCause,
  output logic             donePulse,
  output logic             warnSticky,
  output logic [CNT_W-1:0] lineCount
);

  tbl_strobe_t strb;
  logic        lineHit;
  logic        tableFull;
  phase_e      phaseQ;
  cause_e      causeQ;

  amon_line_table #(
    .MAX_LINES(MAX_LINES),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W)
  ) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .lookTag  (instTag),
    .strb     (strb),
    .lineHit  (lineHit),
    .tableFull(tableFull),
    .lineCount(lineCount)
  );

  amon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instOp    (instOp),
    .instLock  (instLock),
    .lineHit   (lineHit),
    .tableFull (tableFull),
    .strb      (strb),
    .phase     (phaseQ),
    .faultPulse(faultPulse),
    .faultCause(causeQ),
    .donePulse (donePulse),
    .warnSticky(warnSticky)
  );

  assign phase      = phaseQ;
  assign faultCause = causeQ;

endmodule

// File: rtl/atomic_order_monitor_chk.sv
module atomic_order_monitor_chk #(
  parameter int MAX_LINES = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic [2:0]       instOp,
  input logic [1:0]       phase,
  input logic             faultPulse,
  input logic [1:0]       faultCause,
  input logic             donePulse,
  input logic             warnSticky,
  input logic [CNT_W-1:0] lineCount
);

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(faultPulse && donePulse));

  p_cause_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse == (faultCause != 2'b00));

  p_fault_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (phase == 2'b00 && lineCount == '0));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (phase == 2'b00 && lineCount == '0));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    lineCount <= CNT_W'(MAX_LINES));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount != '0) |=> (lineCount <= $past(lineCount) + CNT_W'(1)));

  p_warn_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (warnSticky && !(instValid && instOp == 3'd1 && phase == 2'b00)) |=> warnSticky);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b00 && !(instValid && instOp == 3'd1))
      |=> (phase == 2'b00 && !faultPulse && !donePulse));

endmodule

bind atomic_order_monitor atomic_order_monitor_chk #(
  .MAX_LINES(MAX_LINES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .instOp    (instOp),
  .phase     (phase),
  .faultPulse(faultPulse),
  .faultCause(faultCause),
  .donePulse (donePulse),
  .warnSticky(warnSticky),
  .lineCount (lineCount)
);

// File: tb/atomic_order_monitor_tb.sv
module atomic_order_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LINES  = 8;
  localparam int TAG_W      = 26;
  localparam int CNT_W      = $clog2(MAX_LINES + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             instValid = 1'b0;
  logic [2:0]       instOp = 3'd0;
  logic [TAG_W-1:0] instTag = '0;
  logic             instLock = 1'b0;
  logic [1:0]       phase;
  logic             faultPulse;
  logic [1:0]       faultCause;
  logic             donePulse;
  logic             warnSticky;
  logic [CNT_W-1:0] lineCount;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_order_monitor #(.MAX_LINES(MAX_LINES), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instTag(instTag), .instLock(instLock), .phase(phase),
    .faultPulse(faultPulse), .faultCause(faultCause), .donePulse(donePulse),
    .warnSticky(warnSticky), .lineCount(lineCount)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one instruction, sample the registered result just after the accepting edge
  task automatic issue(input logic [2:0] op, input int tag, input logic lk);
    @(negedge clk);
    instValid = 1'b1; instOp = op; instTag = TAG_W'(tag); instLock = lk;
    @(posedge clk); #1;
    @(negedge clk);
    instValid = 1'b0; instOp = 3'd0; instLock = 1'b0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic expectState(input string req, input int ph, input int flt, input int cause,
                             input int dn, input int wr, input int cnt);
    chk(req, "phase", int'(phase), ph);
    chk(req, "fault", int'(faultPulse), flt);
    chk(req, "cause", int'(faultCause), cause);
    chk(req, "done", int'(donePulse), dn);
    chk(req, "warn", int'(warnSticky), wr);
    chk(req, "count", int'(lineCount), cnt);
  endtask

  task automatic t_reset();
    expectState("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle_ignore();
    issue(3'd2, 5, 1'b0); expectState("R2", 0, 0, 0, 0, 0, 0);
    issue(3'd4, 5, 1'b0); expectState("R2", 0, 0, 0, 0, 0, 0);
    issue(3'd5, 5, 1'b1); expectState("R2", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    issue(3'd1, 0, 1'b0);  expectState("R2", 1, 0, 0, 0, 0, 0);
    issue(3'd2, 10, 1'b0); expectState("R3", 1, 0, 0, 0, 0, 1);
    issue(3'd2, 10, 1'b0); expectState("R3", 1, 0, 0, 0, 0, 1);
    issue(3'd2, 11, 1'b0); expectState("R3", 1, 0, 0, 0, 0, 2);
    issue(3'd4, 0, 1'b0);  expectState("R5", 2, 0, 0, 0, 0, 2);
    issue(3'd5, 10, 1'b0); expectState("R8", 2, 0, 0, 0, 0, 2);
    issue(3'd5, 11, 1'b1); expectState("R9", 0, 0, 0, 1, 0, 0);
    idleCycle();           expectState("R12", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_store_manif();
    issue(3'd1, 0, 1'b0);
    issue(3'd2, 20, 1'b0);
    issue(3'd5, 99, 1'b0); expectState("R8", 1, 0, 0, 0, 0, 1);
    issue(3'd5, 20, 1'b0); expectState("R8", 2, 0, 0, 0, 0, 1);
    issue(3'd2, 21, 1'b0); expectState("R6", 0, 1, 1, 0, 0, 0);
    idleCycle();           expectState("R12", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_plain_part();
    issue(3'd1, 0, 1'b0);
    issue(3'd2, 30, 1'b0);
    issue(3'd4, 0, 1'b0);
    issue(3'd3, 30, 1'b0); expectState("R6", 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_warn();
    issue(3'd1, 0, 1'b0);
    issue(3'd2, 40, 1'b0);
    issue(3'd3, 77, 1'b0); expectState("R7", 1, 0, 0, 0, 0, 1);
    issue(3'd4, 0, 1'b0);
    issue(3'd3, 77, 1'b0); expectState("R7", 2, 0, 0, 0, 1, 1);
    issue(3'd5, 40, 1'b1); expectState("R7", 0, 0, 0, 1, 1, 0);
    issue(3'd1, 0, 1'b0);  expectState("R7", 1, 0, 0, 0, 0, 0);
    issue(3'd5, 40, 1'b1); expectState("R10", 0, 1, 3, 0, 0, 0);
  endtask

  task automatic t_overflow();
    issue(3'd1, 0, 1'b0);
    for (int i = 0; i < MAX_LINES; i++) issue(3'd2, 100 + i, 1'b0);
    expectState("R3", 1, 0, 0, 0, 0, MAX_LINES);
    issue(3'd2, 103, 1'b0); expectState("R4", 1, 0, 0, 0, 0, MAX_LINES);
    issue(3'd2, 500, 1'b0); expectState("R4", 0, 1, 2, 0, 0, 0);
    idleCycle();            expectState("R12", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_query_twice();
    issue(3'd1, 0, 1'b0);
    issue(3'd4, 0, 1'b0); expectState("R5", 2, 0, 0, 0, 0, 0);
    issue(3'd4, 0, 1'b0); expectState("R5", 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_lock_nonpart();
    issue(3'd1, 0, 1'b0);
    issue(3'd2, 50, 1'b0);
    issue(3'd4, 0, 1'b0);
    issue(3'd5, 51, 1'b1); expectState("R10", 0, 1, 3, 0, 0, 0);
  endtask

  task automatic t_setup_lock();
    issue(3'd1, 0, 1'b0);
    issue(3'd2, 60, 1'b0);
    issue(3'd5, 60, 1'b1); expectState("R9", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_nested_start();
    issue(3'd1, 0, 1'b0);
    issue(3'd2, 70, 1'b0);
    issue(3'd1, 0, 1'b0); expectState("R11", 0, 1, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_idle_ignore();
    t_basic();
    t_store_manif();
    t_plain_part();
    t_warn();
    t_overflow();
    t_query_twice();
    t_lock_nonpart();
    t_setup_lock();
    t_nested_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule